// File: doc/BRIEF.md
# Multithreaded Fetch PC Sequencer

This block keeps the fetch program counter for every hardware thread of an in-order pipeline, together with a flag saying whether that counter can be trusted. A fetch stage asks for the next address of a thread and either gets the current PC back, which also serves as the instruction memory address, or is told to stall and retry. A stage that resolves a control instruction reports it here. A taken branch turns into an outgoing squash request. A return whose target was not predicted freezes fetch for its thread and blocks the stage that found it.

Squash requests come back on a small number of lanes per cycle, each tagged with a thread, a sequence number and the kind of instruction that caused it. For each thread the lanes are taken in index order. A later lane wins only when its sequence number is strictly smaller, that is, when it comes from an older instruction than the one already accepted this cycle. An accepted squash redirects the PC. If fetch was frozen, it also releases the blocked stage with a one-cycle unblock pulse. A squash caused by a faulting instruction freezes fetch instead, and a trap later reloads the PC from the architectural value.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: After reset every thread holds PC = BOOT_PC (default 0x1000) with its valid flag set, and stage_block and stage_unblock are all zero.
- R2: A non-faulting request (req_valid=1, req_fault=0) for a valid thread gives req_done=1 and req_stall=0 in the same cycle, with req_pc and req_addr both equal to that thread's PC.
- R3: A non-faulting request for a thread whose valid flag is clear gives req_done=0 and req_stall=1 in the same cycle.
- R4: Anything marked as faulting passes through without effect. A faulting request gives req_done=1 and req_stall=0 whatever the valid flag is. A faulting resolve raises neither a block nor a squash request.
- R5: A resolved control return that was not predicted taken sets bit tid*NSTAGES+stage of stage_block for exactly the next cycle. It also clears the thread's valid flag and records that stage.
- R6: A resolved control instruction predicted taken and not faulting raises squash_out_valid in the same cycle, carrying its tid, stage and sequence number. A non-control instruction raises neither a squash request nor a block.
- R7: Squash lanes for the same thread are considered in index order. The first valid lane is always accepted, and a later lane is accepted only if its sequence number is strictly less than that of the last accepted lane. Threads arbitrate independently, and sq_accept shows the result in the same cycle.
- R8: An accepted squash marked faulting clears the thread's valid flag, so requests stall from the next cycle.
- R9: An accepted squash from a control instruction loads the predicted target into the PC. When the instruction after the branch is present and already sits at that target, the PC is loaded with the target plus 4 instead.
- R10: An accepted squash from a non-control instruction loads that instruction's address plus 4.
- R11: If the thread's valid flag is clear when a non-faulting squash is accepted, bit tid*NSTAGES+recorded stage of stage_unblock is set for exactly the next cycle, and the valid flag is set again.
- R12: A trap sets the thread's valid flag and loads its PC from trap_pc on the next cycle. It overrides any squash or block for that thread in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Next-PC request present |
| req_tid | input | TID_W | Thread of the request |
| req_fault | input | 1 | Requesting instruction already carries a fault |
| req_done | output | 1 | Request completed |
| req_stall | output | 1 | Request must be retried |
| req_pc | output | PC_W | PC handed to the instruction |
| req_addr | output | PC_W | Instruction memory fetch address |
| res_valid | input | 1 | Resolved instruction present |
| res_tid | input | TID_W | Thread of the resolved instruction |
| res_stage | input | STAGE_W | Stage that resolved it |
| res_seq | input | SEQ_W | Its sequence number |
| res_control | input | 1 | It is a control instruction |
| res_return | input | 1 | It is a return |
| res_pred_taken | input | 1 | It was predicted taken |
| res_fault | input | 1 | It carries a fault |
| squash_out_valid | output | 1 | Squash request for a taken control instruction |
| squash_out_tid | output | TID_W | Thread of the squash request |
| squash_out_stage | output | STAGE_W | Stage the squash starts from |
| squash_out_seq | output | SEQ_W | Squash sequence number |
| sq_valid | input | NSQ | Per-lane incoming squash valid |
| sq_tid | input | NSQ*TID_W | Per-lane thread |
| sq_seq | input | NSQ*SEQ_W | Per-lane squash sequence number |
| sq_fault | input | NSQ | Per-lane cause was faulting |
| sq_control | input | NSQ | Per-lane cause was a control instruction |
| sq_pc | input | NSQ*PC_W | Per-lane address of the causing instruction |
| sq_target | input | NSQ*PC_W | Per-lane predicted target |
| sq_next_present | input | NSQ | Per-lane instruction after the branch exists |
| sq_next_pc | input | NSQ*PC_W | Per-lane address of that following instruction |
| trap_valid | input | 1 | Trap reload |
| trap_tid | input | TID_W | Thread to reload |
| trap_pc | input | PC_W | Architectural PC to load |
| stage_block | output | NTHREADS*NSTAGES | Block pulses, bit tid*NSTAGES+stage |
| stage_unblock | output | NTHREADS*NSTAGES | Unblock pulses, bit tid*NSTAGES+stage |
| sq_accept | output | NSQ | Lane squash accepted this cycle |

## Verification
A wrong PC register appears on req_pc and req_addr at the first request after the bad edge, one cycle after the event that caused it. A stuck or wrong valid flag shows as a stall where completion was due, or the reverse, on the same cycle a request is presented. A wrong recorded block stage only appears later, as an unblock pulse on the wrong bit one cycle after the releasing squash. The bench therefore blocks and releases from a known stage. Arbitration errors show on sq_accept in the same cycle, and one cycle later as the PC of whichever lane won.

// File: rtl/fps_pkg.sv
// Shared constants and types for the fetch PC sequencer.
// Assumes a fixed instruction size; all widths come from the top parameters.
package fps_pkg;
    localparam int unsigned INST_BYTES = 4;

    // How an accepted squash redirects the program counter.
    typedef enum logic [2:0] {
        RD_FAULT,
        RD_TARGET,
        RD_TARGET_SKIP,
        RD_SEQUENTIAL
    } redirect_e;
endpackage

// File: rtl/fps_resolve_dec.sv
// Turns one resolved instruction into a block event or an outgoing squash request.
// Assumes the instruction class flags are decoded upstream; a fault disables both outcomes.
module fps_resolve_dec #(
    parameter int TID_W   = 1,
    parameter int STAGE_W = 3,
    parameter int SEQ_W   = 16
) (
    input  logic               res_valid,
    input  logic [TID_W-1:0]   res_tid,
    input  logic [STAGE_W-1:0] res_stage,
    input  logic [SEQ_W-1:0]   res_seq,
    input  logic               res_control,
    input  logic               res_return,
    input  logic               res_pred_taken,
    input  logic               res_fault,
    output logic               blk_evt,
    output logic               squash_out_valid,
    output logic [TID_W-1:0]   squash_out_tid,
    output logic [STAGE_W-1:0] squash_out_stage,
    output logic [SEQ_W-1:0]   squash_out_seq
);
    logic live_ctrl;

    // Classify the resolved instruction: unknown return target or taken branch.
    always_comb begin
        live_ctrl        = res_valid && !res_fault && res_control;
        blk_evt          = live_ctrl && res_return && !res_pred_taken;
        squash_out_valid = live_ctrl && res_pred_taken;
        squash_out_tid   = res_tid;
        squash_out_stage = res_stage;
        squash_out_seq   = res_seq;
    end
endmodule

// File: rtl/fps_thread_slice.sv
// State of one hardware thread: PC, valid flag and recorded blocking stage.
// Applies, in order, a block from resolve, the squash lanes in index order
// (oldest sequence number wins), then a trap, all within one cycle.
// Assumes sequence numbers do not wrap within the comparison window.
module fps_thread_slice #(
    parameter int              THREAD_ID = 0,
    parameter int              NSQ       = 2,
    parameter int              TID_W     = 1,
    parameter int              SEQ_W     = 16,
    parameter int              PC_W      = 32,
    parameter int              NSTAGES   = 5,
    parameter int              STAGE_W   = 3,
    parameter logic [PC_W-1:0] BOOT_PC   = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   blk_evt,
    input  logic [TID_W-1:0]       res_tid,
    input  logic [STAGE_W-1:0]     res_stage,
    input  logic [NSQ-1:0]         sq_valid,
    input  logic [NSQ*TID_W-1:0]   sq_tid,
    input  logic [NSQ*SEQ_W-1:0]   sq_seq,
    input  logic [NSQ-1:0]         sq_fault,
    input  logic [NSQ-1:0]         sq_control,
    input  logic [NSQ*PC_W-1:0]    sq_pc,
    input  logic [NSQ*PC_W-1:0]    sq_target,
    input  logic [NSQ-1:0]         sq_next_present,
    input  logic [NSQ*PC_W-1:0]    sq_next_pc,
    input  logic                   trap_valid,
    input  logic [TID_W-1:0]       trap_tid,
    input  logic [PC_W-1:0]        trap_pc,
    output logic [PC_W-1:0]        pc_q,
    output logic                   valid_q,
    output logic [NSQ-1:0]         acc,
    output logic [NSTAGES-1:0]     blk_q,
    output logic [NSTAGES-1:0]     unb_q
);
    import fps_pkg::*;

    localparam logic [TID_W-1:0] ME   = TID_W'(THREAD_ID);
    localparam logic [PC_W-1:0]  STEP = PC_W'(INST_BYTES);

    logic [STAGE_W-1:0] bstage_q, bs_n;
    logic [PC_W-1:0]    p_n;
    logic               v_n, have, trap_hit;
    logic [SEQ_W-1:0]   best;
    logic [NSTAGES-1:0] blk_d, unb_d;
    redirect_e          kind;

    // Next state: block, then squash lanes in order, then trap override.
    always_comb begin
        v_n      = valid_q;
        p_n      = pc_q;
        bs_n     = bstage_q;
        blk_d    = '0;
        unb_d    = '0;
        acc      = '0;
        have     = 1'b0;
        best     = '1;
        kind     = RD_SEQUENTIAL;
        trap_hit = trap_valid && (trap_tid == ME);
        if (blk_evt && res_tid == ME) begin
            blk_d[res_stage] = 1'b1;
            v_n              = 1'b0;
            bs_n             = res_stage;
        end
        for (int i = 0; i < NSQ; i++) begin
            if (sq_valid[i] && sq_tid[i*TID_W +: TID_W] == ME &&
                (!have || sq_seq[i*SEQ_W +: SEQ_W] < best)) begin
                acc[i] = 1'b1;
                have   = 1'b1;
                best   = sq_seq[i*SEQ_W +: SEQ_W];
                if (sq_fault[i])
                    kind = RD_FAULT;
                else if (!sq_control[i])
                    kind = RD_SEQUENTIAL;
                else if (sq_next_present[i] &&
                         sq_next_pc[i*PC_W +: PC_W] == sq_target[i*PC_W +: PC_W])
                    kind = RD_TARGET_SKIP;
                else
                    kind = RD_TARGET;
                case (kind)
                    RD_FAULT:       p_n = p_n;
                    RD_TARGET:      p_n = sq_target[i*PC_W +: PC_W];
                    RD_TARGET_SKIP: p_n = sq_target[i*PC_W +: PC_W] + STEP;
                    default:        p_n = sq_pc[i*PC_W +: PC_W] + STEP;
                endcase
                if (kind == RD_FAULT) begin
                    v_n = 1'b0;
                end else begin
                    if (!v_n) unb_d[bs_n] = 1'b1;
                    v_n = 1'b1;
                end
            end
        end
        if (trap_hit) begin
            v_n = 1'b1;
            p_n = trap_pc;
        end
    end

    // Thread state and one-cycle block/unblock pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= BOOT_PC;
            valid_q  <= 1'b1;
            bstage_q <= '0;
            blk_q    <= '0;
            unb_q    <= '0;
        end else begin
            pc_q     <= p_n;
            valid_q  <= v_n;
            bstage_q <= bs_n;
            blk_q    <= blk_d;
            unb_q    <= unb_d;
        end
    end

    // R12: a trap reloads this thread and leaves it valid.
    a_r12_trap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        trap_hit |=> (valid_q && pc_q == $past(trap_pc)));

    // R11: valid only comes back through a trap or a release pulse.
    a_r11_valid_return: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> ($past(trap_hit) || (|unb_q)));

    // R5: an unresolved return with nothing else this cycle freezes fetch and blocks.
    a_r5_block_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_evt && res_tid == ME && acc == '0 && !trap_hit) |=> (!valid_q && (|blk_q)));

    // R8: a lone faulting squash leaves the thread frozen.
    a_r8_fault_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == NSQ'(1) && sq_fault[0] && !trap_hit) |=> !valid_q);
endmodule

// File: rtl/fps_fetch_port.sv
// Answers a next-PC request from the per-thread PC and valid state.
// Assumes req_tid names an existing thread; faulting requests complete untouched.
module fps_fetch_port #(
    parameter int NTHREADS = 2,
    parameter int TID_W    = 1,
    parameter int PC_W     = 32
) (
    input  logic                     req_valid,
    input  logic [TID_W-1:0]         req_tid,
    input  logic                     req_fault,
    input  logic [NTHREADS*PC_W-1:0] pcs,
    input  logic [NTHREADS-1:0]      valids,
    output logic                     req_done,
    output logic                     req_stall,
    output logic [PC_W-1:0]          req_pc,
    output logic [PC_W-1:0]          req_addr
);
    logic sel_valid;

    // Select the thread's state and decide complete or stall.
    always_comb begin
        sel_valid = valids[req_tid];
        req_pc    = pcs[req_tid*PC_W +: PC_W];
        req_addr  = req_pc;
        req_done  = req_valid && (req_fault || sel_valid);
        req_stall = req_valid && !req_fault && !sel_valid;
    end
endmodule

// File: rtl/fetch_pc_sequencer.sv
// Fetch PC sequencer for an in-order multithreaded pipeline.
// Holds one PC and valid flag per thread, serves next-PC requests, blocks on
// unpredicted returns, arbitrates same-cycle squashes by sequence number and
// reloads on traps. Assumes at most one request, one resolve and one trap per cycle.
module fetch_pc_sequencer #(
    parameter int              NTHREADS = 2,
    parameter int              NSQ      = 2,
    parameter int              NSTAGES  = 5,
    parameter int              SEQ_W    = 16,
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] BOOT_PC  = 32'h0000_1000,
    localparam int             TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1,
    localparam int             STAGE_W  = (NSTAGES > 1) ? $clog2(NSTAGES) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [TID_W-1:0]            req_tid,
    input  logic                        req_fault,
    output logic                        req_done,
    output logic                        req_stall,
    output logic [PC_W-1:0]             req_pc,
    output logic [PC_W-1:0]             req_addr,
    input  logic                        res_valid,
    input  logic [TID_W-1:0]            res_tid,
    input  logic [STAGE_W-1:0]          res_stage,
    input  logic [SEQ_W-1:0]            res_seq,
    input  logic                        res_control,
    input  logic                        res_return,
    input  logic                        res_pred_taken,
    input  logic                        res_fault,
    output logic                        squash_out_valid,
    output logic [TID_W-1:0]            squash_out_tid,
    output logic [STAGE_W-1:0]          squash_out_stage,
    output logic [SEQ_W-1:0]            squash_out_seq,
    input  logic [NSQ-1:0]              sq_valid,
    input  logic [NSQ*TID_W-1:0]        sq_tid,
    input  logic [NSQ*SEQ_W-1:0]        sq_seq,
    input  logic [NSQ-1:0]              sq_fault,
    input  logic [NSQ-1:0]              sq_control,
    input  logic [NSQ*PC_W-1:0]         sq_pc,
    input  logic [NSQ*PC_W-1:0]         sq_target,
    input  logic [NSQ-1:0]              sq_next_present,
    input  logic [NSQ*PC_W-1:0]         sq_next_pc,
    input  logic                        trap_valid,
    input  logic [TID_W-1:0]            trap_tid,
    input  logic [PC_W-1:0]             trap_pc,
    output logic [NTHREADS*NSTAGES-1:0] stage_block,
    output logic [NTHREADS*NSTAGES-1:0] stage_unblock,
    output logic [NSQ-1:0]              sq_accept
);
    logic                     blk_evt;
    logic [NTHREADS*PC_W-1:0] pcs;
    logic [NTHREADS-1:0]      valids;
    logic [NSQ-1:0]           acc_t [NTHREADS];

    fps_resolve_dec #(.TID_W(TID_W), .STAGE_W(STAGE_W), .SEQ_W(SEQ_W)) u_dec (
        .res_valid(res_valid), .res_tid(res_tid), .res_stage(res_stage),
        .res_seq(res_seq), .res_control(res_control), .res_return(res_return),
        .res_pred_taken(res_pred_taken), .res_fault(res_fault),
        .blk_evt(blk_evt), .squash_out_valid(squash_out_valid),
        .squash_out_tid(squash_out_tid), .squash_out_stage(squash_out_stage),
        .squash_out_seq(squash_out_seq)
    );

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        fps_thread_slice #(
            .THREAD_ID(t), .NSQ(NSQ), .TID_W(TID_W), .SEQ_W(SEQ_W), .PC_W(PC_W),
            .NSTAGES(NSTAGES), .STAGE_W(STAGE_W), .BOOT_PC(BOOT_PC)
        ) u_slice (
            .clk(clk), .rst_n(rst_n), .blk_evt(blk_evt), .res_tid(res_tid),
            .res_stage(res_stage), .sq_valid(sq_valid), .sq_tid(sq_tid),
            .sq_seq(sq_seq), .sq_fault(sq_fault), .sq_control(sq_control),
            .sq_pc(sq_pc), .sq_target(sq_target), .sq_next_present(sq_next_present),
            .sq_next_pc(sq_next_pc), .trap_valid(trap_valid), .trap_tid(trap_tid),
            .trap_pc(trap_pc), .pc_q(pcs[t*PC_W +: PC_W]), .valid_q(valids[t]),
            .acc(acc_t[t]), .blk_q(stage_block[t*NSTAGES +: NSTAGES]),
            .unb_q(stage_unblock[t*NSTAGES +: NSTAGES])
        );
    end

    // Merge per-thread lane acceptance; each lane belongs to one thread.
    always_comb begin
        sq_accept = '0;
        for (int t = 0; t < NTHREADS; t++) sq_accept = sq_accept | acc_t[t];
    end

    fps_fetch_port #(.NTHREADS(NTHREADS), .TID_W(TID_W), .PC_W(PC_W)) u_port (
        .req_valid(req_valid), .req_tid(req_tid), .req_fault(req_fault),
        .pcs(pcs), .valids(valids), .req_done(req_done), .req_stall(req_stall),
        .req_pc(req_pc), .req_addr(req_addr)
    );

    // R3: a request never both completes and stalls.
    a_r3_done_xor_stall: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_done && req_stall));

    // R7: two neighbouring accepted lanes of one thread must get strictly older.
    for (genvar i = 1; i < NSQ; i++) begin : g_arb_chk
        a_r7_older_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (sq_accept[i] && sq_accept[i-1] &&
             sq_tid[i*TID_W +: TID_W] == sq_tid[(i-1)*TID_W +: TID_W])
            |-> (sq_seq[i*SEQ_W +: SEQ_W] < sq_seq[(i-1)*SEQ_W +: SEQ_W]));
    end
endmodule

// File: tb/fetch_pc_sequencer_test.sv
module fetch_pc_sequencer_test;
    localparam int NT = 2, NQ = 2, NS = 5;

    typedef struct packed {
        logic v; logic t; logic [15:0] s; logic f; logic c;
        logic [31:0] pc; logic [31:0] tg; logic np; logic [31:0] npc;
    } lane_t;
    typedef struct packed {
        lane_t a; lane_t b; logic [1:0] acc; logic [31:0] epc; logic ev;
    } row_t;

    localparam lane_t L0 = '0;
    localparam int NROWS = 9;
    localparam row_t ROWS [NROWS] = '{
        '{'{1,0,16'd10,0,1,32'h0,32'h2000,0,32'h0}, L0, 2'b01, 32'h2000, 1'b1},
        '{'{1,0,16'd20,0,0,32'h3000,32'h0,0,32'h0}, L0, 2'b01, 32'h3004, 1'b1},
        '{'{1,0,16'd30,0,1,32'h0,32'h4000,1,32'h4000}, L0, 2'b01, 32'h4004, 1'b1},
        '{'{1,0,16'd31,0,1,32'h0,32'h5000,1,32'h5008}, L0, 2'b01, 32'h5000, 1'b1},
        '{'{1,0,16'd40,0,0,32'h6000,32'h0,0,32'h0},
          '{1,0,16'd35,0,1,32'h0,32'h7000,0,32'h0}, 2'b11, 32'h7000, 1'b1},
        '{'{1,0,16'd35,0,1,32'h0,32'h7100,0,32'h0},
          '{1,0,16'd35,0,0,32'h8000,32'h0,0,32'h0}, 2'b01, 32'h7100, 1'b1},
        '{'{1,0,16'd20,0,1,32'h0,32'h7200,0,32'h0},
          '{1,0,16'd50,0,0,32'h8000,32'h0,0,32'h0}, 2'b01, 32'h7200, 1'b1},
        '{'{1,1,16'd5,0,1,32'h0,32'h9000,0,32'h0},
          '{1,0,16'd60,0,0,32'hA000,32'h0,0,32'h0}, 2'b11, 32'hA004, 1'b1},
        '{'{1,0,16'd70,1,0,32'hA004,32'h0,0,32'h0}, L0, 2'b01, 32'h0, 1'b0}
    };

    logic clk = 0, rst_n = 0;
    logic req_valid, req_tid, req_fault, req_done, req_stall;
    logic [31:0] req_pc, req_addr;
    logic res_valid, res_tid, res_control, res_return, res_pred_taken, res_fault;
    logic [2:0] res_stage;
    logic [15:0] res_seq;
    logic squash_out_valid, squash_out_tid;
    logic [2:0] squash_out_stage;
    logic [15:0] squash_out_seq;
    logic [NQ-1:0] sq_valid, sq_tid, sq_fault, sq_control, sq_next_present, sq_accept;
    logic [NQ*16-1:0] sq_seq;
    logic [NQ*32-1:0] sq_pc, sq_target, sq_next_pc;
    logic trap_valid, trap_tid;
    logic [31:0] trap_pc;
    logic [NT*NS-1:0] stage_block, stage_unblock;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    fetch_pc_sequencer uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_tid = 0; req_fault = 0;
        res_valid = 0; res_tid = 0; res_stage = 0; res_seq = 0; res_control = 0;
        res_return = 0; res_pred_taken = 0; res_fault = 0;
        sq_valid = 0; sq_tid = 0; sq_seq = 0; sq_fault = 0; sq_control = 0;
        sq_pc = 0; sq_target = 0; sq_next_present = 0; sq_next_pc = 0;
        trap_valid = 0; trap_tid = 0; trap_pc = 0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk); idle(); #2;
    endtask

    task automatic set_lane(int i, lane_t l);
        sq_valid[i] = l.v; sq_tid[i] = l.t; sq_seq[i*16 +: 16] = l.s;
        sq_fault[i] = l.f; sq_control[i] = l.c; sq_pc[i*32 +: 32] = l.pc;
        sq_target[i*32 +: 32] = l.tg; sq_next_present[i] = l.np;
        sq_next_pc[i*32 +: 32] = l.npc;
    endtask

    task automatic ask(logic tid, logic flt);
        req_valid = 1; req_tid = tid; req_fault = flt; #1;
    endtask

    task automatic resolve(logic tid, logic [2:0] st, logic [15:0] sq,
                           logic c, logic r, logic pt, logic f);
        res_valid = 1; res_tid = tid; res_stage = st; res_seq = sq;
        res_control = c; res_return = r; res_pred_taken = pt; res_fault = f; #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1; #2;
        // R1 reset state and R2 request on a valid thread
        chk("R1 block", 32'(stage_block), 0);
        chk("R1 unblock", 32'(stage_unblock), 0);
        ask(0, 0);
        chk("R1 pc t0", req_pc, 32'h1000);
        chk("R2 done", 32'(req_done), 1);
        chk("R2 stall", 32'(req_stall), 0);
        chk("R2 addr", req_addr, 32'h1000);
        ask(1, 0);
        chk("R1 pc t1", req_pc, 32'h1000);
        idle();

        // R7 R8 R9 R10: squash vector table on thread 0
        for (int k = 0; k < NROWS; k++) begin
            @(negedge clk);
            set_lane(0, ROWS[k].a); set_lane(1, ROWS[k].b); #2;
            chk($sformatf("R7 accept row%0d", k), 32'(sq_accept), 32'(ROWS[k].acc));
            step();
            ask(0, 0);
            if (ROWS[k].ev) begin
                chk($sformatf("R9/R10 pc row%0d", k), req_pc, ROWS[k].epc);
            end else begin
                chk("R8 fault squash stalls", 32'(req_stall), 1);
                chk("R3 stall no done", 32'(req_done), 0);
            end
            idle();
        end
        ask(1, 0);
        chk("R7 thread1 independent", req_pc, 32'h9000);
        idle();

        // R4 faulting request on a frozen thread still completes
        ask(0, 1);
        chk("R4 fault req done", 32'(req_done), 1);
        chk("R4 fault req no stall", 32'(req_stall), 0);
        idle();

        // R12 trap restores thread 0
        @(negedge clk);
        trap_valid = 1; trap_tid = 0; trap_pc = 32'hB000;
        step();
        ask(0, 0);
        chk("R12 trap pc", req_pc, 32'hB000);
        chk("R12 trap valid", 32'(req_done), 1);
        idle();

        // R5 unpredicted return on thread 0, stage 3 -> bit 3
        @(negedge clk);
        resolve(0, 3'd3, 16'd7, 1, 1, 0, 0);
        chk("R6 no squash for untaken return", 32'(squash_out_valid), 0);
        step();
        chk("R5 block bit", 32'(stage_block), 32'h8);
        ask(0, 0);
        chk("R5 valid cleared", 32'(req_stall), 1);
        idle();
        step();
        chk("R5 single pulse", 32'(stage_block), 0);

        // R11 non-control squash releases the recorded stage
        @(negedge clk);
        set_lane(0, '{1,0,16'd1,0,0,32'hC000,32'h0,0,32'h0});
        step();
        chk("R11 unblock bit", 32'(stage_unblock), 32'h8);
        ask(0, 0);
        chk("R11 pc", req_pc, 32'hC004);
        chk("R11 valid back", 32'(req_done), 1);
        idle();
        step();
        chk("R11 single pulse", 32'(stage_unblock), 0);

        // R4 faulting resolve has no effect; R5 on thread 1 stage 2 -> bit 7
        @(negedge clk);
        resolve(1, 3'd2, 16'd9, 1, 1, 0, 1);
        chk("R4 fault resolve no squash", 32'(squash_out_valid), 0);
        step();
        chk("R4 fault resolve no block", 32'(stage_block), 0);
        @(negedge clk);
        resolve(1, 3'd2, 16'd9, 1, 1, 0, 0);
        step();
        chk("R5 block bit t1", 32'(stage_block), 32'h80);
        ask(1, 0);
        chk("R3 t1 stall", 32'(req_stall), 1);
        chk("R3 t1 no done", 32'(req_done), 0);
        idle();

        // R6 taken control raises squash request; non-control does not
        @(negedge clk);
        resolve(0, 3'd4, 16'h1234, 1, 0, 1, 0);
        chk("R6 squash valid", 32'(squash_out_valid), 1);
        chk("R6 squash stage", 32'(squash_out_stage), 4);
        chk("R6 squash seq", 32'(squash_out_seq), 32'h1234);
        chk("R6 squash tid", 32'(squash_out_tid), 0);
        resolve(0, 3'd4, 16'h1234, 0, 1, 1, 0);
        chk("R6 non-control no squash", 32'(squash_out_valid), 0);
        step();
        chk("R6 non-control no block", 32'(stage_block), 0);

        // R12 trap overrides a same-cycle squash on thread 0
        @(negedge clk);
        set_lane(0, '{1,0,16'd3,0,1,32'h0,32'hE000,0,32'h0});
        trap_valid = 1; trap_tid = 0; trap_pc = 32'hD000;
        step();
        ask(0, 0);
        chk("R12 trap priority", req_pc, 32'hD000);
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule